// File: doc/BRIEF.md
# Seven-Input Majority Voter

This block decides whether at least four of its seven vote inputs are set. It does not use a flat sum-of-products. The four low vote bits first go through a 4:3 parallel counter. Its three weight signals are built in XOR-AND (ring) form:

- the weight-one bit is the parity of the four bits;
- the weight-two bit is the XOR of their six pairwise products;
- the weight-four bit is the product of all four.

A threshold stage adds this three-bit count to the number of ones among the three upper votes. It raises the verdict when the total reaches four.

The verdict and the four-bit group count leave the block through an output register by default, so results appear one clock after the votes are sampled. A parameter can select a purely combinational path instead. A neighbour that needs the partial tally of the low group can take it from the count output.

Top module: `maj7_vote`

## Requirements
- R1: `maj_o` is 1 exactly when at least four of the seven bits of `votes_i` are 1, and 0 otherwise.
- R2: Bit 0 of `count_o` is the XOR of `votes_i[3:0]`.
- R3: Bit 1 of `count_o` is the XOR of the six pairwise ANDs of `votes_i[3:0]`.
- R4: Bit 2 of `count_o` is the AND of `votes_i[3:0]`.
- R5: The AND of `count_o[0]` and `count_o[1]` equals the XOR of the four triple ANDs of `votes_i[3:0]`.
- R6: Whenever `count_o[2]` is 1, both `count_o[1]` and `count_o[0]` are 0.
- R7: `count_o`, read as an unsigned binary number, equals the number of ones in `votes_i[3:0]`.
- R8: While `rst_n` is low, `maj_o` and `count_o` are 0 whatever the votes are.
- R9: With the default registered output, `maj_o` and `count_o` reflect the votes sampled at the previous rising clock edge and hold between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| votes_i | input | 7 | Vote bits; bits 3..0 feed the 4:3 counter |
| maj_o | output | 1 | Majority verdict |
| count_o | output | 3 | Binary count of ones in votes_i[3:0] |

## Verification
The assertions assume that `votes_i` is stable and fully known at each rising edge once reset has been released. The one-cycle checks compare the registered outputs with the votes sampled at the prior edge. The bench respects this by changing `votes_i` only on falling edges and never driving X or Z. It then sweeps all 128 vote patterns, so every group count from zero to four meets every upper-vote total.

// File: rtl/maj7_pkg.sv
package maj7_pkg;
    localparam int unsigned N_VOTES  = 7;
    localparam int unsigned N_GROUP  = 4;
    localparam int unsigned N_REST   = N_VOTES - N_GROUP;
    localparam int unsigned CNT_W    = $clog2(N_GROUP + 1);
    localparam int unsigned TOT_W    = $clog2(N_VOTES + 1);
    localparam int unsigned THRESH   = (N_VOTES + 1) / 2;

    typedef struct packed {
        logic             maj;
        logic [CNT_W-1:0] cnt;
    } vote_out_t;
endpackage

// File: rtl/maj7_quad_counter.sv
module maj7_quad_counter
    import maj7_pkg::*;
(
    input  logic [N_GROUP-1:0] grp_i,
    output logic               w1_o,
    output logic               w2_o,
    output logic               w4_o
);
    always_comb begin
        w1_o = 1'b0;
        w2_o = 1'b0;
        w4_o = 1'b1;
        for (int i = 0; i < int'(N_GROUP); i++) begin
            w1_o = w1_o ^ grp_i[i];
            w4_o = w4_o & grp_i[i];
            for (int j = i + 1; j < int'(N_GROUP); j++) begin
                w2_o = w2_o ^ (grp_i[i] & grp_i[j]);
            end
        end
    end
endmodule

// File: rtl/maj7_threshold.sv
module maj7_threshold
    import maj7_pkg::*;
(
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [N_REST-1:0] rest_i,
    output logic              maj_o
);
    logic [TOT_W-1:0] rest_pop;
    logic [TOT_W-1:0] total;

    always_comb begin
        rest_pop = '0;
        for (int k = 0; k < int'(N_REST); k++) begin
            rest_pop = rest_pop + TOT_W'(rest_i[k]);
        end
        total = TOT_W'(cnt_i) + rest_pop;
        maj_o = (total >= TOT_W'(THRESH));
    end
endmodule

// File: rtl/maj7_vote.sv
module maj7_vote
    import maj7_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_VOTES-1:0]  votes_i,
    output logic                maj_o,
    output logic [CNT_W-1:0]    count_o
);
    logic      w1, w2, w4;
    logic      maj_c;
    vote_out_t out_d;
    vote_out_t out_q;

    maj7_quad_counter u_cnt (
        .grp_i (votes_i[N_GROUP-1:0]),
        .w1_o  (w1),
        .w2_o  (w2),
        .w4_o  (w4)
    );

    maj7_threshold u_thr (
        .cnt_i  ({w4, w2, w1}),
        .rest_i (votes_i[N_VOTES-1:N_GROUP]),
        .maj_o  (maj_c)
    );

    always_comb begin
        out_d     = '0;
        out_d.cnt = {w4, w2, w1};
        out_d.maj = maj_c;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_q <= '0;
                end else begin
                    out_q <= out_d;
                end
            end
        end else begin : g_comb
            always_comb out_q = out_d;
        end
    endgenerate

    assign maj_o   = out_q.maj;
    assign count_o = out_q.cnt;
endmodule

// File: rtl/maj7_vote_chk.sv
module maj7_vote_chk
    import maj7_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_VOTES-1:0] votes_i,
    input logic               w1,
    input logic               w2,
    input logic               w4,
    input logic               maj_o,
    input logic [CNT_W-1:0]   count_o
);
    logic [3:0] g;
    logic       tri_xor;
    assign g       = votes_i[3:0];
    assign tri_xor = (g[0] & g[1] & g[2]) ^ (g[0] & g[1] & g[3])
                   ^ (g[0] & g[2] & g[3]) ^ (g[1] & g[2] & g[3]);

    // R7
    group_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {w4, w2, w1} == CNT_W'($countones(votes_i[N_GROUP-1:0])));

    // R6
    top_weight_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w4 |-> (!w1 && !w2));

    // R5
    triple_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1 & w2) == tri_xor);

    generate
        if (REG_OUT) begin : g_reg_chk
            // R1
            verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> maj_o == ($countones($past(votes_i)) >= THRESH));
            // R9
            count_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> count_o == CNT_W'($countones($past(votes_i[N_GROUP-1:0]))));
        end else begin : g_comb_chk
            // R1
            verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
                maj_o == ($countones(votes_i) >= THRESH));
        end
    endgenerate
endmodule

bind maj7_vote maj7_vote_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .votes_i (votes_i),
    .w1      (w1),
    .w2      (w2),
    .w4      (w4),
    .maj_o   (maj_o),
    .count_o (count_o)
);

// File: tb/maj7_vote_bench.sv
module maj7_vote_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] votes = '0;
    logic       maj_o;
    logic [2:0] count_o;
    int         n_cmp = 0;
    int         n_bad = 0;
    logic       prev_maj = 1'b0;
    logic [2:0] prev_cnt = 3'd0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    maj7_vote u_maj7_vote (
        .clk     (clk),
        .rst_n   (rst_n),
        .votes_i (votes),
        .maj_o   (maj_o),
        .count_o (count_o)
    );

    // {expected verdict, votes}
    localparam logic [7:0] DIRECTED [10] = '{
        {1'b0, 7'b0000000}, {1'b1, 7'b1111111}, {1'b1, 7'b0001111},
        {1'b0, 7'b1110000}, {1'b1, 7'b1110001}, {1'b0, 7'b0000111},
        {1'b1, 7'b1001011}, {1'b1, 7'b0110110}, {1'b0, 7'b0101010},
        {1'b1, 7'b1111110}
    };

    function automatic int pop(input logic [6:0] v, input int n);
        int c = 0;
        for (int i = 0; i < n; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic cmp(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [6:0] v, input int has_exp, input logic exp_maj);
        logic [3:0] g;
        logic       em;
        logic [2:0] ec;
        logic       tx;
        g  = v[3:0];
        em = (pop(v, 7) >= 4);
        ec = 3'(pop(v, 4));
        tx = (g[0]&g[1]&g[2]) ^ (g[0]&g[1]&g[3]) ^ (g[0]&g[2]&g[3]) ^ (g[1]&g[2]&g[3]);
        @(negedge clk);
        votes = v;
        #1;
        // R9: outputs hold until the next edge
        cmp("R9 hold maj", int'(maj_o), int'(prev_maj));
        cmp("R9 hold cnt", int'(count_o), int'(prev_cnt));
        @(posedge clk);
        #1;
        cmp("R1 verdict", int'(maj_o), int'(em));
        if (has_exp != 0) cmp("R1 table", int'(maj_o), int'(exp_maj));
        cmp("R7 count", int'(count_o), int'(ec));
        cmp("R2 parity", int'(count_o[0]), int'(^g));
        cmp("R3 pairs", int'(count_o[1]),
            int'((g[0]&g[1])^(g[0]&g[2])^(g[0]&g[3])^(g[1]&g[2])^(g[1]&g[3])^(g[2]&g[3])));
        cmp("R4 all", int'(count_o[2]), int'(&g));
        cmp("R5 triples", int'(count_o[0] & count_o[1]), int'(tx));
        if (count_o[2]) cmp("R6 exclusive", int'(count_o[1:0]), 0);
        prev_maj = em;
        prev_cnt = ec;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R8: reset holds outputs low with all votes set
        votes = 7'h7F;
        repeat (3) @(posedge clk);
        #1;
        cmp("R8 reset maj", int'(maj_o), 0);
        cmp("R8 reset cnt", int'(count_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        votes = '0;
        @(posedge clk);
        #1;
        prev_maj = 1'b0;
        prev_cnt = 3'd0;

        foreach (DIRECTED[i]) apply(DIRECTED[i][6:0], 1, DIRECTED[i][7]);
        for (int v = 0; v < 128; v++) apply(7'(v), 0, 1'b0);

        // R8: reset reasserted mid-run clears a high verdict
        apply(7'h7F, 1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        cmp("R8 mid reset maj", int'(maj_o), 0);
        cmp("R8 mid reset cnt", int'(count_o), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule